// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block sits beside a processor core and counts what the core does. It holds one cycle counter and four 32-bit event counters. Each event counter watches one of 256 single-bit event lines, picked by an 8-bit type field. A counter advances only when the block-wide run bit and that counter's own enable bit are both set.

Software reaches the block through a small register port. The port has a 4-bit address, a write strobe with write data, and a read strobe with combinational read data. Enables and interrupt enables are changed through separate set and clear addresses, so one counter can be changed without a read-modify-write of the others. The event counters and their type fields are reached indirectly, through a selector register.

To take a sample every N events, software loads a counter with the two's-complement negative of N. The counter then wraps to zero after exactly N counts. The wrap sets that counter's overflow flag, and a flag whose interrupt enable is set drives a level interrupt until software clears the flag.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every register reads zero and irqOut is low. regRdData is zero whenever regRdEn is low.
- R2: The cycle counter (address 7) adds one on every clock edge at which the run bit and enable bit 31 are both set. Otherwise it holds its value. A write to address 7 loads it directly.
- R3: Event counter k adds one on each edge at which it is enabled, the run bit is set, and eventIn[type k] is high. It ignores every other event line.
- R4: Address 1 sets and address 2 clears counter enables for each written one. Zero bits change nothing. Bits 0-3 are event counters 0-3 and bit 31 is the cycle counter; the other bits are ignored. Both addresses read back the enable vector.
- R5: At address 0, bit 0 is the run bit. Writing bit 1 as one zeroes all event counters, and writing bit 2 as one zeroes the cycle counter. A read returns only the run bit.
- R6: Address 6 holds the selected event counter index (0-3). Address 8 (count) and address 9 (8-bit type) read and write only the selected counter, and the other counters keep their values.
- R7: A counter that steps from all ones to zero sets its overflow flag. A counter loaded with -N wraps after exactly N counts.
- R8: Address 5 reads the overflow flags, using the enable bit mapping. Writing ones clears the matching flags, and zero bits change nothing.
- R9: Address 3 sets and address 4 clears interrupt enables, using the same bit mapping. irqOut is high while any flag has its interrupt enable set, and stays high until that flag is cleared or its enable is removed.
- R10: If a flag clear and a new overflow of the same counter happen on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Combinational read data, zero when idle |
| eventIn | input | 256 | Event lines from the core |
| irqOut | output | 1 | Level overflow interrupt |

## Verification
A wrong count, type or enable inside the block shows up as a wrong value in the next readback of that counter. The error grows by one with each misrouted event or cycle, so a sweep over many cycles makes even a single-edge slip visible. A flag or interrupt-enable fault reaches irqOut combinationally in the same cycle, so the bench samples irqOut on the cycle before the wrap and on the wrap cycle itself. A fault in the selector shows up as values leaking between counters, so all four counters are read back after the others have been exercised.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  parameter int NUM_EVT = 4;
  parameter int CNT_W = 32;
  parameter int TYPE_W = 8;
  parameter int REG_W = 32;
  parameter int ADDR_W = 4;
  parameter int CYC_BIT = REG_W - 1;
  localparam int NUM_SRC = 1 << TYPE_W;
  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int CYC_IDX = NUM_EVT;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_IESET = 4'd3;
  localparam logic [ADDR_W-1:0] A_IECLR = 4'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEL = 4'd6;
  localparam logic [ADDR_W-1:0] A_CYC = 4'd7;
  localparam logic [ADDR_W-1:0] A_EVCNT = 4'd8;
  localparam logic [ADDR_W-1:0] A_EVTYPE = 4'd9;

  typedef struct packed {
    logic ctrlWr;
    logic enSet;
    logic enClr;
    logic ieSet;
    logic ieClr;
    logic flagClr;
    logic cycWr;
    logic evtWr;
    logic typeWr;
    logic [REG_W-1:0] wdata;
  } pmuStrobe_t;

  function automatic logic [REG_W-1:0] toBus(input logic [NUM_EVT:0] v);
    logic [REG_W-1:0] b;
    b = '0;
    b[NUM_EVT-1:0] = v[NUM_EVT-1:0];
    b[CYC_BIT] = v[CYC_IDX];
    return b;
  endfunction

  function automatic logic [NUM_EVT:0] fromBus(input logic [REG_W-1:0] b);
    return {b[CYC_BIT], b[NUM_EVT-1:0]};
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         wrapped
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (clear) count <= '0;
    else if (load) count <= loadVal;
    else if (run) count <= count + W'(1);
  end

  assign wrapped = run && !clear && !load && (count == {W{1'b1}});
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              regRdEn,
  output logic [REG_W-1:0]  regRdData,
  input  logic [NUM_EVT:0]  cntEn,
  input  logic [NUM_EVT:0]  irqEn,
  input  logic [NUM_EVT:0]  ovfFlag,
  input  logic [CNT_W-1:0]  cycCount,
  input  logic [CNT_W-1:0]  selCount,
  input  logic [TYPE_W-1:0] selType,
  output pmuStrobe_t        strobe,
  output logic              globalEn,
  output logic [SEL_W-1:0]  evtSel
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      evtSel <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_CTRL) globalEn <= regWrData[0];
      if (regAddr == A_SEL) evtSel <= regWrData[SEL_W-1:0];
    end
  end

  always_comb begin
    strobe = '0;
    strobe.wdata = regWrData;
    if (regWrEn) begin
      case (regAddr)
        A_CTRL:   strobe.ctrlWr = 1'b1;
        A_ENSET:  strobe.enSet = 1'b1;
        A_ENCLR:  strobe.enClr = 1'b1;
        A_IESET:  strobe.ieSet = 1'b1;
        A_IECLR:  strobe.ieClr = 1'b1;
        A_FLAG:   strobe.flagClr = 1'b1;
        A_CYC:    strobe.cycWr = 1'b1;
        A_EVCNT:  strobe.evtWr = 1'b1;
        A_EVTYPE: strobe.typeWr = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        A_CTRL:           regRdData = REG_W'(globalEn);
        A_ENSET, A_ENCLR: regRdData = toBus(cntEn);
        A_IESET, A_IECLR: regRdData = toBus(irqEn);
        A_FLAG:           regRdData = toBus(ovfFlag);
        A_SEL:            regRdData = REG_W'(evtSel);
        A_CYC:            regRdData = REG_W'(cycCount);
        A_EVCNT:          regRdData = REG_W'(selCount);
        A_EVTYPE:         regRdData = REG_W'(selType);
        default:          regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pmuStrobe_t        strobe,
  input  logic              globalEn,
  input  logic [SEL_W-1:0]  evtSel,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [NUM_EVT:0]  cntEn,
  output logic [NUM_EVT:0]  irqEn,
  output logic [NUM_EVT:0]  ovfFlag,
  output logic [CNT_W-1:0]  cycCount,
  output logic [CNT_W-1:0]  selCount,
  output logic [TYPE_W-1:0] selType,
  output logic              irqOut
);
  logic [TYPE_W-1:0] evtType [NUM_EVT];
  logic [CNT_W-1:0]  evtCount [NUM_EVT];
  logic [NUM_EVT:0]  wrapVec;
  logic [NUM_EVT:0]  wrMask;
  logic              evtRst;
  logic              cycRst;

  assign wrMask = fromBus(strobe.wdata);
  assign evtRst = strobe.ctrlWr && strobe.wdata[1];
  assign cycRst = strobe.ctrlWr && strobe.wdata[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEn <= '0;
      irqEn <= '0;
      ovfFlag <= '0;
    end else begin
      if (strobe.enSet) cntEn <= cntEn | wrMask;
      if (strobe.enClr) cntEn <= cntEn & ~wrMask;
      if (strobe.ieSet) irqEn <= irqEn | wrMask;
      if (strobe.ieClr) irqEn <= irqEn & ~wrMask;
      ovfFlag <= (ovfFlag & ~(strobe.flagClr ? wrMask : '0)) | wrapVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_EVT; i++) evtType[i] <= '0;
    end else if (strobe.typeWr) begin
      evtType[evtSel] <= strobe.wdata[TYPE_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk),
      .rstN(rstN),
      .run(globalEn && cntEn[i] && eventIn[evtType[i]]),
      .clear(evtRst),
      .load(strobe.evtWr && (evtSel == SEL_W'(i))),
      .loadVal(strobe.wdata[CNT_W-1:0]),
      .count(evtCount[i]),
      .wrapped(wrapVec[i])
    );
  end

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk(clk),
    .rstN(rstN),
    .run(globalEn && cntEn[CYC_IDX]),
    .clear(cycRst),
    .load(strobe.cycWr),
    .loadVal(strobe.wdata[CNT_W-1:0]),
    .count(cycCount),
    .wrapped(wrapVec[CYC_IDX])
  );

  assign selCount = evtCount[evtSel];
  assign selType = evtType[evtSel];
  assign irqOut = |(ovfFlag & irqEn);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               regRdEn,
  output logic [REG_W-1:0]   regRdData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irqOut
);
  pmuStrobe_t        strobe;
  logic              globalEn;
  logic [SEL_W-1:0]  evtSel;
  logic [NUM_EVT:0]  cntEn;
  logic [NUM_EVT:0]  irqEn;
  logic [NUM_EVT:0]  ovfFlag;
  logic [CNT_W-1:0]  cycCount;
  logic [CNT_W-1:0]  selCount;
  logic [TYPE_W-1:0] selType;

  pmu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .cntEn(cntEn), .irqEn(irqEn), .ovfFlag(ovfFlag), .cycCount(cycCount),
    .selCount(selCount), .selType(selType), .strobe(strobe),
    .globalEn(globalEn), .evtSel(evtSel)
  );

  pmu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .globalEn(globalEn),
    .evtSel(evtSel), .eventIn(eventIn), .cntEn(cntEn), .irqEn(irqEn),
    .ovfFlag(ovfFlag), .cycCount(cycCount), .selCount(selCount),
    .selType(selType), .irqOut(irqOut)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [REG_W-1:0]  regRdData,
  input logic              irqOut,
  input logic              globalEn,
  input logic [NUM_EVT:0]  cntEn,
  input logic [NUM_EVT:0]  ovfFlag,
  input logic [CNT_W-1:0]  cycCount
);
  logic cycTouched;
  logic flagWr;
  logic irqDrop;
  assign cycTouched = regWrEn && (regAddr == A_CTRL || regAddr == A_CYC);
  assign flagWr = regWrEn && (regAddr == A_FLAG);
  assign irqDrop = regWrEn && (regAddr == A_FLAG || regAddr == A_IECLR);

  p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |-> regRdData == '0);

  p_cyc_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && cntEn[CYC_IDX] && !cycTouched) |=> cycCount == $past(cycCount) + CNT_W'(1));

  p_cyc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(globalEn && cntEn[CYC_IDX]) && !cycTouched) |=> $stable(cycCount));

  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (globalEn && cntEn[CYC_IDX] && !cycTouched && cycCount == {CNT_W{1'b1}}) |=> ovfFlag[CYC_IDX]);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> (ovfFlag & $past(ovfFlag)) == $past(ovfFlag));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqDrop) |=> irqOut);
endmodule

bind perf_mon_unit pmu_checker u_pmuChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regRdData(regRdData), .irqOut(irqOut),
  .globalEn(globalEn), .cntEn(cntEn), .ovfFlag(ovfFlag), .cycCount(cycCount)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWrData = '0;
  logic         regRdEn = 1'b0;
  logic [31:0]  regRdData;
  logic [255:0] eventIn = '0;
  logic         irqOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;
  logic [31:0] expCnt [4];

  perf_mon_unit dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .eventIn(eventIn), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) rdChk("R1 reset readback", 4'(a), 32'h0);
    check("R1 irq after reset", 32'(irqOut), 32'h0);
    check("R1 idle read data", regRdData, 32'h0);

    // R4 enable set/clear
    wr(1, 32'h8000_0005);
    rdChk("R4 enable set", 1, 32'h8000_0005);
    wr(1, 32'h0);
    rdChk("R4 zero set no effect", 2, 32'h8000_0005);
    wr(2, 32'h0000_0001);
    rdChk("R4 enable clear", 1, 32'h8000_0004);
    wr(2, 32'h0);
    rdChk("R4 zero clear no effect", 1, 32'h8000_0004);
    wr(1, 32'h7FFF_FFF0);
    rdChk("R4 unmapped bits ignored", 1, 32'h8000_0004);
    wr(2, 32'hFFFF_FFFF);
    rdChk("R4 clear all", 1, 32'h0);

    // R9 interrupt enable set/clear mapping
    wr(3, 32'h8000_000A);
    rdChk("R9 irq enable set", 3, 32'h8000_000A);
    wr(4, 32'h0000_0008);
    rdChk("R9 irq enable clear", 4, 32'h8000_0002);
    wr(4, 32'hFFFF_FFFF);

    // R2 cycle counting
    wr(7, 32'd100);
    wr(1, 32'h8000_0000);
    wr(0, 32'h1);
    rdChk("R5 run bit readback", 0, 32'h1);
    repeat (10) @(negedge clk);
    wr(0, 32'h0);
    rdChk("R2 cycle count after run", 7, 32'd111);
    repeat (5) @(negedge clk);
    rdChk("R2 cycle holds when stopped", 7, 32'd111);
    wr(2, 32'h8000_0000);
    wr(0, 32'h1);
    repeat (5) @(negedge clk);
    wr(0, 32'h0);
    rdChk("R2 cycle holds when disabled", 7, 32'd111);
    wr(0, 32'h4);
    rdChk("R5 cycle reset bit", 7, 32'h0);
    rdChk("R5 reset bits read zero", 0, 32'h0);

    // R3/R6 event counter sweep
    for (int i = 0; i < 4; i++) begin
      int t;
      logic [31:0] exp;
      t = i * 61 + 7;
      wr(2, 32'hFFFF_FFFF);
      wr(6, 32'(i));
      wr(9, 32'(t));
      rdChk("R6 type readback", 9, 32'(t));
      wr(8, 32'h0);
      wr(1, 32'h1 << i);
      wr(0, 32'h1);
      exp = 0;
      for (int c = 0; c < 24; c++) begin
        logic hit;
        hit = ((c * (i + 3)) % 3) != 0 || (c % 5 == 0);
        eventIn = '0;
        eventIn[t] = hit;
        eventIn[(t + 1) % 256] = 1'b1;
        eventIn[(t + 255) % 256] = ~hit;
        if (hit) exp = exp + 1;
        @(negedge clk);
      end
      eventIn = '0;
      wr(0, 32'h0);
      expCnt[i] = exp;
      rdChk("R3 event count", 8, exp);
    end
    for (int i = 0; i < 4; i++) begin
      wr(6, 32'(i));
      rdChk("R6 selected counters independent", 8, expCnt[i]);
      rdChk("R6 selector readback", 6, 32'(i));
    end

    // R5 event counter reset leaves cycle counter
    wr(7, 32'd55);
    wr(0, 32'h2);
    for (int i = 0; i < 4; i++) begin
      wr(6, 32'(i));
      rdChk("R5 event reset bit", 8, 32'h0);
    end
    rdChk("R5 event reset spares cycle", 7, 32'd55);

    // R7/R9/R8 cycle overflow with period 3
    wr(2, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFD);
    wr(1, 32'h8000_0000);
    wr(3, 32'h8000_0000);
    wr(0, 32'h1);
    repeat (2) @(negedge clk);
    rdChk("R7 no flag before wrap", 5, 32'h0);
    rdChk("R7 count before wrap", 7, 32'hFFFF_FFFF);
    check("R9 irq low before wrap", 32'(irqOut), 32'h0);
    @(negedge clk);
    rdChk("R7 flag after wrap", 5, 32'h8000_0000);
    rdChk("R7 count after wrap", 7, 32'h0);
    check("R9 irq on wrap", 32'(irqOut), 32'h1);
    wr(0, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 irq holds", 32'(irqOut), 32'h1);
    wr(5, 32'h0);
    rdChk("R8 zero clear no effect", 5, 32'h8000_0000);
    wr(4, 32'h8000_0000);
    check("R9 irq masked", 32'(irqOut), 32'h0);
    wr(3, 32'h8000_0000);
    check("R9 irq unmasked", 32'(irqOut), 32'h1);
    wr(5, 32'h8000_0000);
    rdChk("R8 flag cleared", 5, 32'h0);
    check("R9 irq after clear", 32'(irqOut), 32'h0);

    // R7 event counter period 5 on counter 2
    wr(2, 32'hFFFF_FFFF);
    wr(6, 32'd2);
    wr(9, 32'd200);
    wr(8, 32'hFFFF_FFFB);
    wr(1, 32'h4);
    eventIn[200] = 1'b1;
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    rdChk("R7 event no flag at N-1", 5, 32'h0);
    @(negedge clk);
    rdChk("R7 event flag at N", 5, 32'h4);
    eventIn = '0;
    wr(0, 32'h0);
    wr(5, 32'h4);

    // R10 clear and overflow on the same edge, counter 1
    wr(2, 32'hFFFF_FFFF);
    wr(6, 32'd1);
    wr(9, 32'd9);
    wr(8, 32'hFFFF_FFFF);
    wr(1, 32'h2);
    eventIn[9] = 1'b1;
    wr(0, 32'h1);
    wr(5, 32'h2);
    eventIn = '0;
    wr(0, 32'h0);
    rdChk("R10 overflow beats clear", 5, 32'h2);
    rdChk("R10 counter wrapped", 8, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule